// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a processor core and decides, each cycle it is idle, whether to take a reset request, a non-maskable interrupt or a maskable level interrupt. The core shows its current program counter, status word and stack pointer on plain input pins. When an interrupt is taken, the block stores the return address and then the status word below the stack pointer through a valid/ready memory-write port. After both stores are accepted, it raises a one-cycle commit strobe. On that strobe it presents the new program counter, status word and stack pointer, and the core loads them.

The new program counter is a fixed base plus either a fixed offset (non-maskable) or a 16-bit per-level vector. Software reads and writes the vectors on a small register bus. A level interrupt controller outside the block drives the pending level with a strobe. That level stays pending, even after it has been delivered, until the controller drives a new value. Each level delivery pulses an acknowledge that carries the level.

Write-port back-pressure: once `mw_valid` is high, the address, data and size stay stable and valid stays high until a cycle in which `mw_ready` is high. A store completes in that cycle. The two stores of one entry are never reordered. `mw_ready` may stay low for any number of cycles, and the entry waits.

Top module: `irq_entry_seq`

## Requirements
- R1: Fixed priority per evaluation, with only one taken: a pending reset request first, then a pending non-maskable request, then a level request.
- R2: A non-maskable entry performs two stores in order. The first is a 32-bit store of `pc_in` at `sp_in`-4 (`mw_half`=0). The second is a 16-bit store of `psw_in` at `sp_in`-8 (`mw_half`=1, data zero-extended). It then commits with `pc_out`=0x40000008, `sp_out`=`sp_in`-8 and `psw_out` equal to `psw_in` with bit 11 (interrupt enable) cleared. The pending non-maskable request is cleared when it is taken.
- R3: A level request is taken only when the pending level is strictly below the status-word mask field (bits 10:8) and bit 11 is set. A blocked request is re-evaluated every idle cycle. Level 7 means nothing is pending.
- R4: A level entry stores the same two words as R2 and clears bit 11. It replaces bits 10:8 with the delivered level and commits `sp_out`=`sp_in`-8 and `pc_out`=0x40000000 plus the zero-extended vector of that level.
- R5: `ack_valid` is high for exactly the commit cycle of a level entry, with `ack_level` equal to the delivered level. It stays low for non-maskable entries.
- R6: Delivery does not clear the pending level. Only a `lvl_strobe` (which loads `lvl_value`) or a reset request changes it.
- R7: Register reads are 16 bits. Vector n (0 to 6) sits at offset 4·n, offset 0x20 reads the constant `IMC_VALUE`, offset 0x40 reads the constant `MODE_VALUE`, and every other offset reads 0.
- R8: A write with `reg_wide`=1 to a vector offset updates that vector. Narrow writes and writes to any other offset, including 0x20 and 0x40, change nothing.
- R9: A taken reset request clears all vectors and the pending non-maskable request, sets the pending level to 7 and makes no store.
- R10: Until `mw_ready` is seen, `mw_valid`, `mw_addr`, `mw_data` and `mw_half` hold their values. `commit` rises only after both stores are accepted, never while a store is outstanding.
- R11: After `rst_n` is released, no store and no commit are made, the pending level is 7 and all vectors read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Pulse: post a reset request |
| nmi_req | input | 1 | Pulse: post a non-maskable request |
| lvl_strobe | input | 1 | Load `lvl_value` as the pending level |
| lvl_value | input | 3 | New pending level (7 = none) |
| pc_in | input | 32 | Core program counter |
| psw_in | input | 16 | Core status word |
| sp_in | input | 32 | Core stack pointer |
| mw_valid | output | 1 | Store request valid |
| mw_ready | input | 1 | Store accepted |
| mw_addr | output | 32 | Store byte address |
| mw_data | output | 32 | Store data |
| mw_half | output | 1 | 1: 16-bit store, 0: 32-bit store |
| commit | output | 1 | One-cycle strobe: load new PC/PSW/SP |
| pc_out | output | 32 | New program counter |
| psw_out | output | 16 | New status word |
| sp_out | output | 32 | New stack pointer |
| ack_valid | output | 1 | Level delivered this cycle |
| ack_level | output | 3 | Delivered level |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1: write, 0: read |
| reg_wide | input | 1 | 1: 16-bit access |
| reg_ofs | input | 7 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_ofs` |

## Verification
The bench aims at the mask boundary: a level equal to the mask field must stay blocked, so an off-by-one comparison would take it. It posts a non-maskable request together with a level in the same cycle and expects the non-maskable entry. A design that clears the pending level on delivery would miss the second delivery of the same level once the mask is opened again. A reset request posted together with a non-maskable request must produce no entry, wipe the vectors and return the level to idle. A design that skipped those clears would take a stale interrupt later. Random ready stalls check that the stores stay ordered and that the commit waits for both stores. Narrow writes and writes to the constant registers must leave every register unchanged.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_COMMIT
  } seq_state_t;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_RESET,
    EV_NMI,
    EV_LEVEL
  } ev_kind_t;
endpackage

// File: rtl/irq_vec_regfile.sv
module irq_vec_regfile #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 16,
  parameter int OFS_W = 7,
  parameter logic [OFS_W-1:0] IMC_OFS = 7'h20,
  parameter logic [OFS_W-1:0] MODE_OFS = 7'h40,
  parameter logic [VEC_W-1:0] IMC_VALUE = '0,
  parameter logic [VEC_W-1:0] MODE_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic             bus_wide,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic [VEC_W-1:0] bus_wdata,
  output logic [VEC_W-1:0] bus_rdata,
  input  logic [LVL_W-1:0] lookup_idx,
  output logic [VEC_W-1:0] lookup_vec
);
  localparam int NUM_VEC = (1 << LVL_W) - 1;

  logic [VEC_W-1:0] vec_q [NUM_VEC];
  logic             wr_ok;

  assign wr_ok = bus_valid && bus_write && bus_wide;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    localparam logic [OFS_W-1:0] VEC_OFS = OFS_W'(4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_q[i] <= '0;
      else if (clear)
        vec_q[i] <= '0;
      else if (wr_ok && bus_ofs == VEC_OFS)
        vec_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_ofs == IMC_OFS) bus_rdata = IMC_VALUE;
    if (bus_ofs == MODE_OFS) bus_rdata = MODE_VALUE;
    for (int i = 0; i < NUM_VEC; i++)
      if (bus_ofs == OFS_W'(4 * i)) bus_rdata = vec_q[i];
  end

  always_comb begin
    lookup_vec = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (lookup_idx == LVL_W'(i)) lookup_vec = vec_q[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int PSW_W = 16,
  parameter int IE_BIT = 11,
  parameter int LM_LSB = 8
) (
  input  logic             rst_pend,
  input  logic             nmi_pend,
  input  logic [LVL_W-1:0] lvl_pend,
  input  logic [PSW_W-1:0] psw,
  output ev_kind_t         kind
);
  logic [LVL_W-1:0] mask_lvl;
  assign mask_lvl = psw[LM_LSB +: LVL_W];

  always_comb begin
    kind = EV_NONE;
    if (rst_pend)
      kind = EV_RESET;
    else if (nmi_pend)
      kind = EV_NMI;
    else if (psw[IE_BIT] && (lvl_pend < mask_lvl))
      kind = EV_LEVEL;
  end
endmodule

// File: rtl/irq_push_fsm.sv
module irq_push_fsm
  import irq_seq_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ADDR_W = 32,
  parameter int PSW_W = 16,
  parameter int VEC_W = 16,
  parameter int IE_BIT = 11,
  parameter int LM_LSB = 8,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] NMI_OFS = 32'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_kind_t          kind,
  input  logic [LVL_W-1:0]  lvl_pend,
  input  logic [VEC_W-1:0]  vec_val,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              idle,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [ADDR_W-1:0] mw_data,
  output logic              mw_half,
  output logic              commit,
  output logic [ADDR_W-1:0] pc_out,
  output logic [PSW_W-1:0]  psw_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              ack_valid,
  output logic [LVL_W-1:0]  ack_level
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(8);

  seq_state_t        state_q;
  logic              is_lvl_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [ADDR_W-1:0] pc_q, sp_q, tgt_q;
  logic [PSW_W-1:0]  psw_q;
  logic              start;

  assign idle  = (state_q == ST_IDLE);
  assign start = idle && (kind == EV_NMI || kind == EV_LEVEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_lvl_q <= 1'b0;
      lvl_q    <= '0;
      pc_q     <= '0;
      psw_q    <= '0;
      sp_q     <= '0;
      tgt_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          is_lvl_q <= (kind == EV_LEVEL);
          lvl_q    <= lvl_pend;
          pc_q     <= pc_in;
          psw_q    <= psw_in;
          sp_q     <= sp_in;
          tgt_q    <= (kind == EV_LEVEL) ? TARGET_BASE + ADDR_W'(vec_val)
                                         : TARGET_BASE + NMI_OFS;
          state_q  <= ST_PUSH_PC;
        end
        ST_PUSH_PC:  if (mw_ready) state_q <= ST_PUSH_PSW;
        ST_PUSH_PSW: if (mw_ready) state_q <= ST_COMMIT;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mw_valid = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW);
    mw_half  = (state_q == ST_PUSH_PSW);
    mw_addr  = mw_half ? sp_q - FRAME_BYTES : sp_q - WORD_BYTES;
    mw_data  = mw_half ? {{(ADDR_W-PSW_W){1'b0}}, psw_q} : pc_q;
  end

  always_comb begin
    psw_out = psw_q;
    psw_out[IE_BIT] = 1'b0;
    if (is_lvl_q) psw_out[LM_LSB +: LVL_W] = lvl_q;
  end

  assign commit    = (state_q == ST_COMMIT);
  assign pc_out    = tgt_q;
  assign sp_out    = sp_q - FRAME_BYTES;
  assign ack_valid = commit && is_lvl_q;
  assign ack_level = lvl_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ADDR_W = 32,
  parameter int PSW_W = 16,
  parameter int VEC_W = 16,
  parameter int OFS_W = 7,
  parameter int IE_BIT = 11,
  parameter int LM_LSB = 8,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] NMI_OFS = 32'h8,
  parameter logic [VEC_W-1:0] IMC_VALUE = 16'h0A05,
  parameter logic [VEC_W-1:0] MODE_VALUE = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic              lvl_strobe,
  input  logic [LVL_W-1:0]  lvl_value,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [ADDR_W-1:0] mw_data,
  output logic              mw_half,
  output logic              commit,
  output logic [ADDR_W-1:0] pc_out,
  output logic [PSW_W-1:0]  psw_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              ack_valid,
  output logic [LVL_W-1:0]  ack_level,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_wide,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [VEC_W-1:0]  reg_wdata,
  output logic [VEC_W-1:0]  reg_rdata
);
  localparam logic [LVL_W-1:0] NONE_LVL = '1;

  ev_kind_t         kind;
  logic             idle;
  logic             rst_pend_q, nmi_pend_q;
  logic [LVL_W-1:0] lvl_pend_q;
  logic [VEC_W-1:0] vec_val;
  logic             rst_take, nmi_take;

  assign rst_take = idle && (kind == EV_RESET);
  assign nmi_take = idle && (kind == EV_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      lvl_pend_q <= NONE_LVL;
    end else begin
      if (rst_take) rst_pend_q <= 1'b0;
      else if (reset_req) rst_pend_q <= 1'b1;

      if (rst_take) nmi_pend_q <= 1'b0;
      else if (nmi_req) nmi_pend_q <= 1'b1;
      else if (nmi_take) nmi_pend_q <= 1'b0;

      if (rst_take) lvl_pend_q <= NONE_LVL;
      else if (lvl_strobe) lvl_pend_q <= lvl_value;
    end
  end

  irq_arbiter #(
    .LVL_W(LVL_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB)
  ) u_arb (
    .rst_pend(rst_pend_q),
    .nmi_pend(nmi_pend_q),
    .lvl_pend(lvl_pend_q),
    .psw(psw_in),
    .kind(kind)
  );

  irq_vec_regfile #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .OFS_W(OFS_W),
    .IMC_VALUE(IMC_VALUE), .MODE_VALUE(MODE_VALUE)
  ) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .clear(rst_take),
    .bus_valid(reg_valid),
    .bus_write(reg_write),
    .bus_wide(reg_wide),
    .bus_ofs(reg_ofs),
    .bus_wdata(reg_wdata),
    .bus_rdata(reg_rdata),
    .lookup_idx(lvl_pend_q),
    .lookup_vec(vec_val)
  );

  irq_push_fsm #(
    .LVL_W(LVL_W), .ADDR_W(ADDR_W), .PSW_W(PSW_W), .VEC_W(VEC_W),
    .IE_BIT(IE_BIT), .LM_LSB(LM_LSB),
    .TARGET_BASE(TARGET_BASE), .NMI_OFS(NMI_OFS)
  ) u_fsm (
    .clk(clk),
    .rst_n(rst_n),
    .kind(kind),
    .lvl_pend(lvl_pend_q),
    .vec_val(vec_val),
    .pc_in(pc_in),
    .psw_in(psw_in),
    .sp_in(sp_in),
    .idle(idle),
    .mw_valid(mw_valid),
    .mw_ready(mw_ready),
    .mw_addr(mw_addr),
    .mw_data(mw_data),
    .mw_half(mw_half),
    .commit(commit),
    .pc_out(pc_out),
    .psw_out(psw_out),
    .sp_out(sp_out),
    .ack_valid(ack_valid),
    .ack_level(ack_level)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int LVL_W = 3,
  parameter int ADDR_W = 32,
  parameter int PSW_W = 16,
  parameter int IE_BIT = 11,
  parameter int LM_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [ADDR_W-1:0] mw_data,
  input logic              mw_half,
  input logic              commit,
  input logic [PSW_W-1:0]  psw_out,
  input logic [ADDR_W-1:0] sp_out,
  input logic              ack_valid,
  input logic [LVL_W-1:0]  ack_level
);
  assert_store_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_half));

  assert_commit_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !mw_valid);

  assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_commit_after_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(mw_valid) && $past(mw_half) && $past(mw_ready) && sp_out == $past(mw_addr));

  assert_ie_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !psw_out[IE_BIT]);

  assert_ack_in_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> commit && ack_level != '1);

  assert_ack_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> psw_out[LM_LSB +: LVL_W] == ack_level);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .LVL_W(LVL_W), .ADDR_W(ADDR_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mw_valid(mw_valid),
  .mw_ready(mw_ready),
  .mw_addr(mw_addr),
  .mw_data(mw_data),
  .mw_half(mw_half),
  .commit(commit),
  .psw_out(psw_out),
  .sp_out(sp_out),
  .ack_valid(ack_valid),
  .ack_level(ack_level)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam logic [15:0] IMC_V  = 16'h0A05;
  localparam logic [15:0] MODE_V = 16'h00C3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reset_req, nmi_req, lvl_strobe, mw_ready;
  logic [2:0]  lvl_value, ack_level;
  logic [31:0] pc_r, sp_r, mw_addr, mw_data, pc_out, sp_out;
  logic [15:0] psw_r, psw_out, reg_wdata, reg_rdata;
  logic        mw_valid, mw_half, commit, ack_valid;
  logic        reg_valid, reg_write, reg_wide;
  logic [6:0]  reg_ofs;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .lvl_strobe(lvl_strobe), .lvl_value(lvl_value),
    .pc_in(pc_r), .psw_in(psw_r), .sp_in(sp_r),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_half(mw_half),
    .commit(commit), .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_wide(reg_wide),
    .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int nchk = 0, nfail = 0;
  int nwr = 0, nvalid = 0, ncommit = 0, nack = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_half [64];
  logic [31:0] c_pc, c_sp;
  logic [15:0] c_psw;
  logic [2:0]  a_lvl;
  logic [15:0] vec_m [7];

  // Memory responder and output monitor, away from the active edge
  initial begin
    mw_ready = 1'b0;
    forever begin
      @(negedge clk);
      mw_ready = ($urandom % 4) != 0;
      if (rst_n === 1'b1) begin
        if (mw_valid) nvalid++;
        if (mw_valid && mw_ready) begin
          log_addr[nwr % 64] = mw_addr;
          log_data[nwr % 64] = mw_data;
          log_half[nwr % 64] = mw_half;
          nwr++;
        end
        if (commit) begin
          c_pc = pc_out; c_psw = psw_out; c_sp = sp_out; ncommit++;
        end
        if (ack_valid) begin
          a_lvl = ack_level; nack++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_psw(input bit ie, input logic [2:0] lm);
    logic [15:0] p = 16'h0000;
    p[11] = ie; p[10:8] = lm;
    return p;
  endfunction

  function automatic logic [15:0] exp_psw(input logic [15:0] p, input bit is_nmi, input logic [2:0] lvl);
    logic [15:0] q = p;
    q[11] = 1'b0;
    if (!is_nmi) q[10:8] = lvl;
    return q;
  endfunction

  task automatic reg_wr(input logic [6:0] ofs, input logic [15:0] d, input bit wide);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_wide = wide; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wide = 1'b1;
  endtask

  task automatic reg_rd(input logic [6:0] ofs, output logic [15:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_ofs = ofs;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic trig(input bit rst, input bit nmi, input bit setl, input logic [2:0] lvl);
    @(negedge clk);
    reset_req = rst; nmi_req = nmi; lvl_strobe = setl; lvl_value = lvl;
    @(negedge clk);
    reset_req = 1'b0; nmi_req = 1'b0; lvl_strobe = 1'b0;
  endtask

  task automatic expect_none(input int cycles, input string req);
    int cb = ncommit, vb = nvalid;
    repeat (cycles) @(negedge clk);
    #1;
    chk(ncommit == cb && nvalid == vb, req, 32'(nvalid - vb), 32'd0);
  endtask

  task automatic expect_entry(input bit is_nmi, input logic [2:0] lvl, input string req);
    int wb = nwr, cb = ncommit, ab = nack;
    logic [31:0] e_pc;
    logic [15:0] e_psw;
    e_pc  = is_nmi ? 32'h4000_0008 : 32'h4000_0000 + {16'h0, vec_m[lvl]};
    e_psw = exp_psw(psw_r, is_nmi, lvl);
    for (int i = 0; i < 80 && ncommit == cb; i++) begin
      @(negedge clk); #1;
    end
    chk(ncommit == cb + 1, req, 32'(ncommit - cb), 32'd1);
    if (ncommit == cb + 1) begin
      chk(nwr == wb + 2, req, 32'(nwr - wb), 32'd2);
      chk(log_addr[wb % 64] == sp_r - 4 && log_data[wb % 64] == pc_r && !log_half[wb % 64],
          req, log_addr[wb % 64], sp_r - 4);
      chk(log_addr[(wb+1) % 64] == sp_r - 8 && log_data[(wb+1) % 64] == {16'h0, psw_r}
          && log_half[(wb+1) % 64], req, log_data[(wb+1) % 64], {16'h0, psw_r});
      chk(c_pc == e_pc, req, c_pc, e_pc);
      chk(c_psw == e_psw, req, {16'h0, c_psw}, {16'h0, e_psw});
      chk(c_sp == sp_r - 8, req, c_sp, sp_r - 8);
      if (is_nmi)
        chk(nack == ab, {req, " R5 no ack"}, 32'(nack - ab), 32'd0);
      else
        chk(nack == ab + 1 && a_lvl == lvl, {req, " R5 ack"}, {29'h0, a_lvl}, {29'h0, lvl});
      pc_r = c_pc; psw_r = c_psw; sp_r = c_sp;
    end
  endtask

  initial begin
    logic [15:0] rd;
    logic [2:0]  lv;
    bit          nm;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reset_req = 1'b0; nmi_req = 1'b0; lvl_strobe = 1'b0; lvl_value = 3'd7;
    reg_valid = 1'b0; reg_write = 1'b0; reg_wide = 1'b1; reg_ofs = '0; reg_wdata = '0;
    pc_r = 32'h0000_1000; psw_r = mk_psw(1'b1, 3'd7); sp_r = 32'h0000_8000;
    for (int i = 0; i < 7; i++) vec_m[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    #1;
    chk(!mw_valid && !commit && !ack_valid, "R11 outputs idle", {29'h0, mw_valid, commit, ack_valid}, 32'd0);
    reg_rd(7'h00, rd);
    chk(rd == 16'h0, "R11 vector zero", {16'h0, rd}, 32'd0);
    expect_none(10, "R11 level idle at 7");

    // R7/R8: register map
    for (int i = 0; i < 7; i++) begin
      vec_m[i] = 16'($urandom);
      reg_wr(7'(4 * i), vec_m[i], 1'b1);
    end
    for (int i = 0; i < 7; i++) begin
      reg_rd(7'(4 * i), rd);
      chk(rd == vec_m[i], "R7 vector readback", {16'h0, rd}, {16'h0, vec_m[i]});
    end
    reg_rd(7'h20, rd); chk(rd == IMC_V, "R7 ofs 0x20", {16'h0, rd}, {16'h0, IMC_V});
    reg_rd(7'h40, rd); chk(rd == MODE_V, "R7 ofs 0x40", {16'h0, rd}, {16'h0, MODE_V});
    reg_rd(7'h1C, rd); chk(rd == 16'h0, "R7 unmapped 0x1C", {16'h0, rd}, 32'd0);
    reg_rd(7'h02, rd); chk(rd == 16'h0, "R7 unmapped 0x02", {16'h0, rd}, 32'd0);
    reg_wr(7'h20, 16'hFFFF, 1'b1);
    reg_rd(7'h20, rd); chk(rd == IMC_V, "R8 write to 0x20 ignored", {16'h0, rd}, {16'h0, IMC_V});
    reg_wr(7'h04, ~vec_m[1], 1'b0);
    reg_rd(7'h04, rd); chk(rd == vec_m[1], "R8 narrow write ignored", {16'h0, rd}, {16'h0, vec_m[1]});
    reg_wr(7'h1C, 16'h1234, 1'b1);
    reg_rd(7'h18, rd); chk(rd == vec_m[6], "R8 unmapped write ignored", {16'h0, rd}, {16'h0, vec_m[6]});

    // R2: non-maskable entry
    psw_r = mk_psw(1'b1, 3'd3) | 16'h0055;
    trig(1'b0, 1'b1, 1'b0, 3'd0);
    expect_entry(1'b1, 3'd0, "R2 nmi entry");
    expect_none(8, "R2 nmi pending cleared");

    // R1/R3/R4/R6: nmi beats level, then level waits for enable
    psw_r = mk_psw(1'b1, 3'd7);
    trig(1'b0, 1'b1, 1'b1, 3'd2);
    expect_entry(1'b1, 3'd0, "R1 nmi over level");
    expect_none(10, "R3 blocked by enable");
    psw_r[11] = 1'b1;
    expect_entry(1'b0, 3'd2, "R4 level entry after enable");
    psw_r[11] = 1'b1;
    expect_none(10, "R3 level equal to mask blocked");
    psw_r[10:8] = 3'd3;
    expect_entry(1'b0, 3'd2, "R6 level persists after delivery");

    // R9/R1: reset request beats nmi, clears state
    psw_r = mk_psw(1'b0, 3'd7);
    trig(1'b0, 1'b0, 1'b1, 3'd1);
    trig(1'b1, 1'b1, 1'b0, 3'd0);
    expect_none(10, "R9 reset request makes no entry");
    for (int i = 0; i < 7; i++) begin
      reg_rd(7'(4 * i), rd);
      chk(rd == 16'h0, "R9 vectors cleared", {16'h0, rd}, 32'd0);
      vec_m[i] = 16'h0;
    end
    psw_r = mk_psw(1'b1, 3'd7);
    expect_none(10, "R9 level back to 7");

    // Random mix (R1 R3 R4 R5)
    for (int i = 0; i < 7; i++) begin
      vec_m[i] = 16'($urandom);
      reg_wr(7'(4 * i), vec_m[i], 1'b1);
    end
    for (int it = 0; it < 40; it++) begin
      pc_r  = $urandom;
      sp_r  = $urandom & 32'hFFFF_FFFC;
      psw_r = 16'($urandom);
      lv    = 3'($urandom);
      nm    = ($urandom % 4) == 0;
      trig(1'b0, nm, 1'b1, lv);
      if (nm)
        expect_entry(1'b1, 3'd0, "R1 random nmi");
      else if (psw_r[11] && lv < psw_r[10:8])
        expect_entry(1'b0, lv, "R4 random level");
      else
        expect_none(8, "R3 random blocked");
      trig(1'b0, 1'b0, 1'b1, 3'd7);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule